// File: doc/BRIEF.md
# CAN Transceiver Transmit Guard Controller

This block is the digital decision logic beside a CAN physical-layer transceiver. It decides, every clock cycle, whether the analog bus driver may pull the bus dominant and whether the receiver path is live. Its inputs are the controller's transmit data line, a mode-select line, two supply-undervoltage flags (core supply and I/O supply) and an overtemperature flag. Every input passes through a two-flop synchroniser before use. After reset, the transmit and mode lines read as high until their synchronisers load, which matches an input pin with a pull-up.

The block has three modes. In power-off it holds everything inactive. In normal it both transmits and receives. In silent it only listens. Several guards can block the driver even in normal mode:
- A dominant-timeout counter stops a transmit line that is stuck low from holding the bus.
- An overtemperature lock keeps the driver off until the flag has cleared and the transmit line has been seen high.
- After undervoltage recovery, the driver stays off until the transmit line has been seen high once.
- After a silent-to-normal change, a settle counter holds the driver off for a fixed number of cycles.

Top module: `can_tx_guard`

## Requirements
- R1: While reset is applied, or while either synchronised undervoltage flag is high, mode_o is 2'b00 (power-off), drv_en_o is 0 and rx_en_o is 0. A supply flag reaches mode_o three cycles after it reaches the pin.
- R2: When both undervoltage flags are clear, the block leaves power-off. It enters normal (mode_o = 2'b01) if the synchronised s_i is 0, or silent (mode_o = 2'b10) if it is 1.
- R3: In normal mode with no guard active, drv_en_o equals the inverse of txd_i delayed by two clock cycles, and rx_en_o is 1.
- R4: In silent mode, drv_en_o is 0 whatever txd_i does, and rx_en_o stays 1.
- R5: After a falling edge on the synchronised transmit line, drv_en_o is high for at most TIMEOUT_CYC consecutive cycles. It then stays 0 for as long as the line stays low.
- R6: A rising edge on the synchronised transmit line clears the timeout. The next falling edge drives dominant again.
- R7: While the synchronised overtemperature flag is high, drv_en_o is 0, and rx_en_o and mode_o are unchanged. The driver returns only once the flag is clear and the transmit line has been seen high.
- R8: After power-off ends, drv_en_o stays 0 until the transmit line has been seen high at least once, even if the line is held low throughout.
- R9: When mode_o changes from silent to normal, drv_en_o is held at 0 for exactly SETTLE_CYC cycles, counted from the first cycle mode_o shows normal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| txd_i | input | 1 | Transmit data from the protocol controller; 0 requests dominant |
| s_i | input | 1 | Mode select; 0 selects normal, 1 selects silent |
| uv_core_i | input | 1 | Core supply undervoltage flag, active high |
| uv_io_i | input | 1 | I/O supply undervoltage flag, active high |
| ot_i | input | 1 | Overtemperature flag, active high |
| drv_en_o | output | 1 | 1 = bus driver asserts dominant this cycle |
| rx_en_o | output | 1 | 1 = receiver path active |
| mode_o | output | 2 | 00 power-off, 01 normal, 10 silent |

## Verification
A wrong internal state in this block shows up at the ports mostly as dominant drive at the wrong time. A timeout counter that is off by one, or that never reloads, changes the length of the drv_en_o pulse while txd_i is held low. That pulse is measured cycle by cycle against TIMEOUT_CYC. A fault lock or an undervoltage arming flag that never clears, or clears too early, shows as drv_en_o missing or present within three cycles of the next low on txd_i. A settle counter that loads the wrong value shifts the first dominant cycle after a silent-to-normal change, so the bench counts the blocked cycles exactly.

// File: rtl/can_guard_pkg.sv
// Shared types for the CAN transmit guard.
// Assumes: the 2-bit mode code is decoded by logic outside this block.
package can_guard_pkg;

    typedef enum logic [1:0] {
        MODE_OFF    = 2'b00,
        MODE_NORMAL = 2'b01,
        MODE_SILENT = 2'b10
    } guard_mode_e;

endpackage

// File: rtl/can_guard_sync.sv
// Multi-bit, multi-stage synchroniser.
// Each bit is an independent slow control line, so no coherence between bits is assumed.
// Assumes STAGES >= 1. RST_VAL gives the value the block reads before the chain has loaded.
module can_guard_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] chain;

    // Shift the raw inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                chain[i] <= RST_VAL;
            end
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/can_guard_domtmr.sv
// Dominant-timeout timer.
// The count starts on a falling edge of the synchronised transmit line.
// The flag sets once the line has stayed low for TIMEOUT_CYC cycles.
// A high line or power-off clears both the count and the flag.
// Assumes TIMEOUT_CYC >= 1.
module can_guard_domtmr #(
    parameter int TIMEOUT_CYC = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic txd_s,
    output logic timed_out
);

    localparam int CW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

    logic          txd_q;
    logic [CW-1:0] cnt;
    logic          fall;

    assign fall = txd_q & ~txd_s;

    // Remember the previous line level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) txd_q <= 1'b1;
        else        txd_q <= txd_s;
    end

    // Count low cycles after a falling edge and set the flag at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            timed_out <= 1'b0;
        end else if (clear || txd_s) begin
            cnt       <= '0;
            timed_out <= 1'b0;
        end else if ((fall || cnt != '0) && !timed_out) begin
            if (cnt == LAST) timed_out <= 1'b1;
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/can_guard_mode_fsm.sv
// Mode state machine with the silent-to-normal settle counter.
// Any undervoltage forces power-off. On exit, the next mode follows the mode line.
// settle_busy stays high for SETTLE_CYC cycles after a silent-to-normal change.
module can_guard_mode_fsm
    import can_guard_pkg::*;
#(
    parameter int SETTLE_CYC = 1250
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        uv_any,
    input  logic        s_s,
    output guard_mode_e mode,
    output logic        settle_busy
);

    localparam int DW = (SETTLE_CYC > 0) ? $clog2(SETTLE_CYC + 1) : 1;
    localparam logic [DW-1:0] DLY_LOAD = DW'(SETTLE_CYC);

    logic [DW-1:0] dly;

    // Mode transitions and settle countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= MODE_OFF;
            dly  <= '0;
        end else if (uv_any) begin
            mode <= MODE_OFF;
            dly  <= '0;
        end else begin
            case (mode)
                MODE_OFF: begin
                    mode <= s_s ? MODE_SILENT : MODE_NORMAL;
                    dly  <= '0;
                end
                MODE_SILENT: begin
                    if (!s_s) begin
                        mode <= MODE_NORMAL;
                        dly  <= DLY_LOAD;
                    end
                end
                MODE_NORMAL: begin
                    if (s_s) begin
                        mode <= MODE_SILENT;
                        dly  <= '0;
                    end else if (dly != '0) begin
                        dly <= dly - 1'b1;
                    end
                end
                default: begin
                    mode <= MODE_OFF;
                    dly  <= '0;
                end
            endcase
        end
    end

    assign settle_busy = (dly != '0);

endmodule

// File: rtl/can_guard_arm.sv
// Re-arm rules after faults.
// supply_armed: cleared in power-off; set once the transmit line is seen high outside power-off.
// thermal_lock: set while the overtemperature flag is high; cleared once the flag is low
// and the transmit line is high.
module can_guard_arm (
    input  logic clk,
    input  logic rst_n,
    input  logic power_off,
    input  logic txd_s,
    input  logic ot_s,
    output logic supply_armed,
    output logic thermal_lock
);

    // Undervoltage re-arm: wait for a high transmit line after power returns.
    always_ff @(posedge clk) begin
        if (!rst_n)         supply_armed <= 1'b0;
        else if (power_off) supply_armed <= 1'b0;
        else if (txd_s)     supply_armed <= 1'b1;
    end

    // Thermal lock: hold until the flag is clear and the line is high.
    always_ff @(posedge clk) begin
        if (!rst_n)     thermal_lock <= 1'b0;
        else if (ot_s)  thermal_lock <= 1'b1;
        else if (txd_s) thermal_lock <= 1'b0;
    end

endmodule

// File: rtl/can_tx_guard.sv
// CAN transceiver transmit guard, top level.
// Synchronises all inputs, runs the mode machine, the dominant timer and the re-arm rules,
// and combines them into the driver and receiver enables.
// Assumes the fault flags are clean levels. The outputs are decoded from registers only.
module can_tx_guard
    import can_guard_pkg::*;
#(
    parameter int TIMEOUT_CYC = 250000,
    parameter int SETTLE_CYC  = 1250,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       txd_i,
    input  logic       s_i,
    input  logic       uv_core_i,
    input  logic       uv_io_i,
    input  logic       ot_i,
    output logic       drv_en_o,
    output logic       rx_en_o,
    output logic [1:0] mode_o
);

    localparam int NSYNC = 5;
    // Bit order: {ot, uv_io, uv_core, s, txd}. Undervoltage, mode and transmit read high before load.
    localparam logic [NSYNC-1:0] SYNC_RST = 5'b01111;

    logic [NSYNC-1:0] raw_in;
    logic [NSYNC-1:0] syn_in;
    logic             txd_s, s_s, uv_any, ot_s;
    guard_mode_e      mode;
    logic             settle_busy, timed_out, supply_armed, thermal_lock;
    logic             power_off;

    assign raw_in = {ot_i, uv_io_i, uv_core_i, s_i, txd_i};

    can_guard_sync #(
        .WIDTH  (NSYNC),
        .STAGES (SYNC_STAGES),
        .RST_VAL(SYNC_RST)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (raw_in),
        .q    (syn_in)
    );

    assign txd_s  = syn_in[0];
    assign s_s    = syn_in[1];
    assign uv_any = syn_in[2] | syn_in[3];
    assign ot_s   = syn_in[4];

    can_guard_mode_fsm #(
        .SETTLE_CYC(SETTLE_CYC)
    ) u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .uv_any     (uv_any),
        .s_s        (s_s),
        .mode       (mode),
        .settle_busy(settle_busy)
    );

    assign power_off = (mode == MODE_OFF);

    can_guard_domtmr #(
        .TIMEOUT_CYC(TIMEOUT_CYC)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (power_off),
        .txd_s    (txd_s),
        .timed_out(timed_out)
    );

    can_guard_arm u_arm (
        .clk         (clk),
        .rst_n       (rst_n),
        .power_off   (power_off),
        .txd_s       (txd_s),
        .ot_s        (ot_s),
        .supply_armed(supply_armed),
        .thermal_lock(thermal_lock)
    );

    // Dominant is allowed only in settled normal mode with every guard released.
    always_comb begin
        drv_en_o = (mode == MODE_NORMAL) && !settle_busy && !txd_s
                   && !timed_out && !thermal_lock && supply_armed;
    end

    assign rx_en_o = !power_off;
    assign mode_o  = mode;

endmodule

// File: rtl/can_tx_guard_chk.sv
// Property checker for can_tx_guard, attached with bind.
// Watches the ports plus the synchronised fault flags, and measures dominant run length with its own counter.
module can_tx_guard_chk #(
    parameter int TIMEOUT_CYC = 250000,
    parameter int SETTLE_CYC  = 1250
) (
    input logic       clk,
    input logic       rst_n,
    input logic       drv_en_o,
    input logic       rx_en_o,
    input logic [1:0] mode_o,
    input logic       uv_any,
    input logic       ot_s
);

    localparam int RW = $clog2(TIMEOUT_CYC + 2);
    localparam logic [RW-1:0] RMAX = RW'(TIMEOUT_CYC + 1);

    logic [RW-1:0] run_len;

    // Count consecutive dominant cycles, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                 run_len <= '0;
        else if (!drv_en_o)         run_len <= '0;
        else if (run_len != RMAX)   run_len <= run_len + 1'b1;
    end

    // R1
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b00) |-> (!drv_en_o && !rx_en_o));

    // R1
    uv_forces_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uv_any |=> (mode_o == 2'b00));

    // R4
    silent_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b10) |-> !drv_en_o);

    // R5
    dom_run_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drv_en_o |-> (run_len < RW'(TIMEOUT_CYC)));

    // R7
    hot_blocks_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ot_s |=> !drv_en_o);

    // R8
    uv_exit_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_o) == 2'b00 && mode_o != 2'b00) |-> !drv_en_o);

    // R9
    settle_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (SETTLE_CYC > 0 && $past(mode_o) == 2'b10 && mode_o == 2'b01) |-> !drv_en_o);

endmodule

bind can_tx_guard can_tx_guard_chk #(
    .TIMEOUT_CYC(TIMEOUT_CYC),
    .SETTLE_CYC (SETTLE_CYC)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .drv_en_o(drv_en_o),
    .rx_en_o (rx_en_o),
    .mode_o  (mode_o),
    .uv_any  (uv_any),
    .ot_s    (ot_s)
);

// File: tb/test_can_tx_guard.sv
// Scoreboard bench for can_tx_guard.
// Stimulus tasks push expected values and observed port values into queues; a monitor pops and compares them.
module test_can_tx_guard;

    localparam int TO  = 40;
    localparam int DLY = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       txd_i = 1'b1, s_i = 1'b0, uv_core_i = 1'b0, uv_io_i = 1'b0, ot_i = 1'b0;
    logic       drv_en_o, rx_en_o;
    logic [1:0] mode_o;

    typedef struct {
        string req;
        string what;
        int    val;
    } sb_item_t;

    sb_item_t exp_q[$];
    int       act_q[$];
    int       n_checks = 0;
    int       n_fails  = 0;
    bit       done     = 1'b0;

    always #4 clk = ~clk;

    can_tx_guard #(
        .TIMEOUT_CYC(TO),
        .SETTLE_CYC (DLY),
        .SYNC_STAGES(2)
    ) i_can_tx_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .txd_i    (txd_i),
        .s_i      (s_i),
        .uv_core_i(uv_core_i),
        .uv_io_i  (uv_io_i),
        .ot_i     (ot_i),
        .drv_en_o (drv_en_o),
        .rx_en_o  (rx_en_o),
        .mode_o   (mode_o)
    );

    // Monitor: pop matching expected/observed pairs and compare.
    initial begin
        forever begin
            @(posedge clk);
            while (exp_q.size() > 0 && act_q.size() > 0) begin
                sb_item_t e;
                int       a;
                e = exp_q.pop_front();
                a = act_q.pop_front();
                n_checks++;
                if (e.val != a) begin
                    n_fails++;
                    $display("FAIL %s %s: actual %0d expected %0d", e.req, e.what, a, e.val);
                end
            end
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic push(input string req, input string what, input int exp_v, input int act_v);
        exp_q.push_back('{req, what, exp_v});
        act_q.push_back(act_v);
    endtask

    task automatic expect_ports(input string req, input int drv, input int rx, input int md);
        push(req, "drv_en_o", drv, int'(drv_en_o));
        push(req, "rx_en_o", rx, int'(rx_en_o));
        push(req, "mode_o", md, int'(mode_o));
    endtask

    // Count cycles with drv_en_o high over a window.
    task automatic count_drive(input int window, output int hits);
        hits = 0;
        for (int i = 0; i < window; i++) begin
            @(negedge clk);
            if (drv_en_o) hits++;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        int hits;
        int waited;
        int zeros;
        bit pattern[6];
        pattern = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};

        step(4);
        // R1: reset state
        expect_ports("R1", 0, 0, 0);
        rst_n = 1'b1;
        step(6);
        // R2: exit to normal with s low; R3 idle with txd high
        expect_ports("R2", 0, 1, 1);

        // R5: exact dominant length after a falling edge
        txd_i = 1'b0;
        count_drive(TO + 8, hits);
        push("R5", "dominant cycles", TO, hits);
        push("R5", "drv after timeout", 0, int'(drv_en_o));

        // R6: rising edge re-arms
        txd_i = 1'b1;
        step(4);
        txd_i = 1'b0;
        step(3);
        push("R6", "drv after re-arm", 1, int'(drv_en_o));
        txd_i = 1'b1;
        step(3);

        // R3: follow a bit pattern with two-cycle latency
        foreach (pattern[k]) begin
            txd_i = pattern[k];
            step(2);
            push("R3", "drv follows txd", int'(!pattern[k]), int'(drv_en_o));
            step(1);
        end
        txd_i = 1'b1;
        step(3);

        // R4: silent mode ignores txd
        s_i = 1'b1;
        step(4);
        expect_ports("R4", 0, 1, 2);
        txd_i = 1'b0;
        step(4);
        push("R4", "drv in silent", 0, int'(drv_en_o));
        txd_i = 1'b1;
        step(3);

        // R9: silent to normal settle delay
        s_i   = 1'b0;
        txd_i = 1'b0;
        waited = 0;
        do begin
            @(negedge clk);
            waited++;
        end while (mode_o != 2'b01 && waited < 10);
        zeros = 0;
        while (!drv_en_o && zeros < 100) begin
            zeros++;
            @(negedge clk);
        end
        push("R9", "settle cycles", DLY, zeros);
        txd_i = 1'b1;
        step(3);

        // R7: overtemperature lock
        txd_i = 1'b0;
        step(3);
        push("R7", "drv before hot", 1, int'(drv_en_o));
        ot_i = 1'b1;
        step(4);
        expect_ports("R7", 0, 1, 1);
        ot_i = 1'b0;
        step(5);
        push("R7", "drv hot cleared txd low", 0, int'(drv_en_o));
        txd_i = 1'b1;
        step(4);
        txd_i = 1'b0;
        step(3);
        push("R7", "drv after recovery", 1, int'(drv_en_o));
        txd_i = 1'b1;
        step(3);

        // R1/R8: core undervoltage then recovery with txd low
        uv_core_i = 1'b1;
        step(4);
        expect_ports("R1", 0, 0, 0);
        txd_i = 1'b0;
        step(2);
        uv_core_i = 1'b0;
        step(5);
        expect_ports("R8", 0, 1, 1);
        txd_i = 1'b1;
        step(3);
        txd_i = 1'b0;
        step(3);
        push("R8", "drv after txd seen high", 1, int'(drv_en_o));
        txd_i = 1'b1;
        step(3);

        // R1/R2: I/O undervoltage, exit into silent
        uv_io_i = 1'b1;
        s_i     = 1'b1;
        step(4);
        expect_ports("R1", 0, 0, 0);
        uv_io_i = 1'b0;
        step(5);
        expect_ports("R2", 0, 1, 2);

        step(4);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule